// File: doc/BRIEF.md
# Card-Specific Data Capacity Encoder

This block turns a storage size, given as a count of 512-byte sectors, into the 128-bit card-specific-data response that a memory card returns to its host. Two fixed 128-bit templates are held in the block, one for standard-capacity cards and one for high-capacity cards. The block picks one of them from the size and then fills in the computed size fields. It also reports which card class was chosen and raises an error flag when the size cannot be encoded.

For a high-capacity card the size is written as one linear 22-bit field. For a standard card the size is written as a 12-bit mantissa and a 3-bit exponent, where capacity = (1 + mantissa) << (exponent + 2) KiB. The exponent is found by halving the size in KiB, one halving per clock, until the value fits. A caller pulses `start` with the size applied, waits for the one-cycle `done` pulse, and reads the response. The response stays valid until the next accepted start.

Top module: `csd_capacity_encoder`

## Requirements
- R1: After reset `busy`, `done`, `high_cap` and `err` are 0 and `resp` is all zero.
- R2: `high_cap` is 1 exactly when sectors × 512 is greater than 2^31 bytes, that is when sectors > 4194304. A size of exactly 2^31 bytes is encoded as a standard card.
- R3: Standard response, as `resp[127:0]` = {word3, word2, word1, word0}: word3 = 0x00260032, word0 = 0x928040CB. word2 = 0x5F5A8000 with bits 9:0 replaced by size field bits 11:2. word1 = 0x3EF84FFF with bits 31:30 replaced by size field bits 1:0 and bits 17:15 replaced by the 3-bit exponent field.
- R4: Standard encoding: start with K = sectors/2 (the size in KiB). Halve K, rounding down, while K > 4096, and count the halvings as n. The size field is K−1 and the exponent field is n−2.
- R5: A standard size with n < 2 is too small. This includes zero sectors. It sets `err`.
- R6: High-capacity response: word3 = 0x400E0032 and word0 = 0x0A4040DF. With m = floor(sectors/1024) − 1: word2 = 0x5B590000 with bits 5:0 replaced by m[21:16], and word1 = 0x00007F80 with bits 31:16 replaced by m[15:0].
- R7: A high-capacity size where m does not fit in 22 bits (m ≥ 4194304) sets `err`.
- R8: When `err` is 1, `resp` is all zero. `err`, `high_cap` and `resp` keep their values after `done` until the next accepted start, which clears `err` and `resp`.
- R9: `done` is high for exactly one cycle. It is high on the (n+2)-th falling edge after the rising edge that accepts `start`, where n = 0 for high-capacity sizes. `busy` is high from that accepting edge until `done` rises, and it is never high together with `done`.
- R10: A `start` pulse while `busy` is high is ignored: the running computation's result and timing are unchanged.
- R11: A `start` applied in the cycle where `done` is high is accepted. The finished result is readable during that cycle, and the new computation follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an encoding; accepted when not busy |
| sectors | input | SECT_W (34) | Storage size in 512-byte sectors, sampled on acceptance |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| resp | output | 128 | Card-specific-data response {word3,word2,word1,word0} |
| high_cap | output | 1 | High-capacity encoding was chosen |
| err | output | 1 | Size cannot be encoded |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. This happens when `start` is held high during the cycle where `done` is high. The bench provokes this by driving a second size at the falling edge where it first sees `done`. It then checks that the first result is still on `resp` at that moment. On the next edge `resp` and `err` must clear, and the second result must arrive with the latency computed for its own halving count. A start pulse placed in the middle of a long halving run is judged the same way: the result and the cycle count must match those of the original size.

// File: rtl/csd_enc_pkg.sv
package csd_enc_pkg;

  localparam logic [31:0] STD_W3 = 32'h0026_0032;
  localparam logic [31:0] STD_W2 = 32'h5F5A_8000;
  localparam logic [31:0] STD_W1 = 32'h3EF8_4FFF;
  localparam logic [31:0] STD_W0 = 32'h9280_40CB;

  localparam logic [31:0] HC_W3 = 32'h400E_0032;
  localparam logic [31:0] HC_W2 = 32'h5B59_0000;
  localparam logic [31:0] HC_W1 = 32'h0000_7F80;
  localparam logic [31:0] HC_W0 = 32'h0A40_40CB ^ 32'h0000_0014;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } enc_state_e;

  // standard card: 12-bit size field split across words 2 and 1, exponent in word 1
  function automatic logic [127:0] merge_std(input logic [11:0] size_f, input logic [2:0] exp_f);
    logic [127:0] r;
    r = {STD_W3, STD_W2, STD_W1, STD_W0};
    r[73:64] = r[73:64] | size_f[11:2];
    r[63:62] = r[63:62] | size_f[1:0];
    r[49:47] = r[49:47] | exp_f;
    return r;
  endfunction

  // high-capacity card: 22-bit linear field split across words 2 and 1
  function automatic logic [127:0] merge_hc(input logic [21:0] m_f);
    logic [127:0] r;
    r = {HC_W3, HC_W2, HC_W1, HC_W0};
    r[69:64] = r[69:64] | m_f[21:16];
    r[63:48] = r[63:48] | m_f[15:0];
    return r;
  endfunction

endpackage

// File: rtl/csd_halver.sv
module csd_halver #(
  parameter int KIB_W     = 33,
  parameter int KIB_LIMIT = 4096,
  parameter int EXP_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KIB_W-1:0] load_kib,
  input  logic             step,
  output logic [KIB_W-1:0] kib,
  output logic [EXP_W-1:0] halvings,
  output logic             above
);
  localparam logic [KIB_W-1:0] LIMIT_V = KIB_W'(KIB_LIMIT);
  localparam logic [EXP_W-1:0] MAX_HALV = EXP_W'(KIB_W);

  assign above = (kib > LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kib      <= '0;
      halvings <= '0;
    end else if (load) begin
      kib      <= load_kib;
      halvings <= '0;
    end else if (step) begin
      kib      <= kib >> 1;
      halvings <= halvings + 1'b1;
    end
  end

  // R4
  halve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (halvings < MAX_HALV) && above);

  // R4
  halve_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (kib < $past(kib)) && (halvings == $past(halvings) + 1'b1));

endmodule

// File: rtl/csd_field_merge.sv
module csd_field_merge #(
  parameter int EXP_W = 6
) (
  input  logic             sel_hc,
  input  logic             fault,
  input  logic [11:0]      size_f,
  input  logic [EXP_W-1:0] exp_f,
  input  logic [21:0]      m_f,
  output logic [127:0]     resp_n
);
  import csd_enc_pkg::*;

  always_comb begin
    if (fault)       resp_n = '0;
    else if (sel_hc) resp_n = merge_hc(m_f);
    else             resp_n = merge_std(size_f, exp_f[2:0]);
  end

  // R8
  fault_blank_chk: assert final (!fault || resp_n == '0);

endmodule

// File: rtl/csd_capacity_encoder.sv
module csd_capacity_encoder #(
  parameter int SECT_W    = 34,
  parameter int KIB_LIMIT = 4096,
  parameter int HC_LOG2   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] sectors,
  output logic              busy,
  output logic              done,
  output logic [127:0]      resp,
  output logic              high_cap,
  output logic              err
);
  import csd_enc_pkg::*;

  localparam int KIB_W = SECT_W - 1;
  localparam int EXP_W = $clog2(KIB_W + 1);
  localparam logic [SECT_W-1:0] HC_SECT = SECT_W'(1) << HC_LOG2;
  localparam int M_W = 22;

  enc_state_e        st;
  logic [SECT_W-1:0] sect_q;
  logic              hc_q;
  logic [KIB_W-1:0]  kib;
  logic [EXP_W-1:0]  halvings;
  logic              above;

  // named events for the checks
  logic accept_evt, step_evt, finish_evt;
  assign accept_evt = start && (st != ST_SHIFT);
  assign step_evt   = (st == ST_SHIFT) && !hc_q && above;
  assign finish_evt = (st == ST_SHIFT) && !step_evt;

  csd_halver #(.KIB_W(KIB_W), .KIB_LIMIT(KIB_LIMIT), .EXP_W(EXP_W)) u_halver (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .load_kib (sectors[SECT_W-1:1]),
    .step     (step_evt),
    .kib      (kib),
    .halvings (halvings),
    .above    (above)
  );

  // high-capacity field
  logic [SECT_W-1:0] m_full;
  logic              hc_fault;
  assign m_full   = (sect_q >> 10) - 1'b1;
  assign hc_fault = (m_full >> M_W) != '0;

  // standard fields
  logic [KIB_W-1:0] size_full;
  logic [EXP_W-1:0] exp_adj;
  logic             too_small, too_large, std_fault;
  assign size_full = kib - 1'b1;
  assign too_small = halvings < EXP_W'(2);
  assign exp_adj   = halvings - EXP_W'(2);
  assign too_large = !too_small && (exp_adj > EXP_W'(7));
  assign std_fault = too_small || too_large;

  logic         fault;
  logic [127:0] resp_n;
  assign fault = hc_q ? hc_fault : std_fault;

  csd_field_merge #(.EXP_W(EXP_W)) u_merge (
    .sel_hc (hc_q),
    .fault  (fault),
    .size_f (size_full[11:0]),
    .exp_f  (exp_adj),
    .m_f    (m_full[M_W-1:0]),
    .resp_n (resp_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sect_q   <= '0;
      hc_q     <= 1'b0;
      resp     <= '0;
      high_cap <= 1'b0;
      err      <= 1'b0;
    end else begin
      case (st)
        ST_SHIFT: begin
          if (finish_evt) begin
            resp     <= resp_n;
            high_cap <= hc_q;
            err      <= fault;
            st       <= ST_DONE;
          end
        end
        default: begin
          if (accept_evt) begin
            sect_q   <= sectors;
            hc_q     <= sectors > HC_SECT;
            resp     <= '0;
            err      <= 1'b0;
            high_cap <= 1'b0;
            st       <= ST_SHIFT;
          end else begin
            st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (st == ST_SHIFT);
  assign done = (st == ST_DONE);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_evt) |=> busy && $stable(sect_q));

  // R8
  err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> resp == '0);

  // R4
  loop_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && !hc_q) |-> kib <= KIB_W'(KIB_LIMIT));

  // R6
  hc_template_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && high_cap && !err) |-> resp[127:96] == HC_W3);

endmodule

// File: tb/tb_csd_capacity_encoder.sv
module tb_csd_capacity_encoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [33:0]  sectors = '0;
  logic         busy, done, high_cap, err;
  logic [127:0] resp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  csd_capacity_encoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sectors(sectors),
    .busy(busy), .done(done), .resp(resp), .high_cap(high_cap), .err(err)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // independent model built from the requirement text
  task automatic model(input logic [33:0] s, output logic [127:0] r, output bit hc,
                       output bit e, output int n);
    longint unsigned cap_b, kib, m;
    logic [31:0] w3, w2, w1, w0;
    cap_b = longint'(s) * 512;
    hc = cap_b > 64'd2147483648;
    n = 0; e = 0;
    if (hc) begin
      m = cap_b / (512 * 1024) - 1;
      e = m >= 64'd4194304;
      w3 = 32'h400E0032; w0 = 32'h0A4040DF;
      w2 = 32'h5B590000 | 32'(m >> 16);
      w1 = 32'h00007F80 | (32'(m & 16'hFFFF) << 16);
    end else begin
      kib = cap_b / 1024;
      for (int i = 0; i < 40; i++) if ((kib >> i) > 4096) n = i + 1;
      kib = kib >> n;
      e = (n < 2) || (n - 2 > 7);
      w3 = 32'h00260032; w0 = 32'h928040CB;
      w2 = 32'h5F5A8000 | 32'(((kib - 1) >> 2) & 10'h3FF);
      w1 = 32'h3EF84FFF | (32'((kib - 1) & 3) << 30) | (32'(n - 2) << 15);
    end
    r = e ? '0 : {w3, w2, w1, w0};
  endtask

  // drive at a negedge; returns at the negedge where done is seen
  task automatic launch_and_wait(input logic [33:0] s, output int cyc, input int poke_at = 0,
                                 input logic [33:0] poke_val = '0);
    start = 1'b1; sectors = s;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 100) begin
      if (poke_at != 0 && cyc == poke_at) begin start = 1'b1; sectors = poke_val; end
      @(negedge clk); start = 1'b0; cyc++;
    end
  endtask

  task automatic run_case(input string tag, input logic [33:0] s);
    logic [127:0] r; bit hc, e; int n, cyc;
    model(s, r, hc, e, n);
    launch_and_wait(s, cyc);
    chk({tag, " R9 latency"}, 128'(cyc), 128'(n + 2));
    chk({tag, " R9 busy low at done"}, 128'(busy), 128'(0));
    chk({tag, " R2 high_cap"}, 128'(high_cap), 128'(hc));
    chk({tag, " err"}, 128'(err), 128'(e));
    chk({tag, " resp"}, resp, r);
    @(negedge clk);
    chk({tag, " R9 done single"}, 128'(done), 128'(0));
  endtask

  task automatic t_reset;
    chk("R1 busy", 128'(busy), 0); chk("R1 done", 128'(done), 0);
    chk("R1 err", 128'(err), 0); chk("R1 high_cap", 128'(high_cap), 0);
    chk("R1 resp", resp, '0);
  endtask

  task automatic t_standard;
    run_case("R3 R4 std min valid", 34'd20000);
    run_case("R3 R4 std 1GiB", 34'd2097152);
    run_case("R2 R4 std exactly 2GiB", 34'd4194304);
    run_case("R4 std odd size", 34'd123457);
  endtask

  task automatic t_small;
    run_case("R5 too small 8MiB", 34'd16384);
    run_case("R5 too small zero", 34'd0);
  endtask

  task automatic t_hc;
    run_case("R2 R6 hc just above", 34'd4194305);
    run_case("R6 hc 64GiB", 34'd134217728);
    run_case("R6 hc max m", 34'h1_0000_03FF);
    run_case("R7 hc overflow", 34'h1_0000_0400);
  endtask

  task automatic t_err_hold;
    logic [127:0] r; bit hc, e; int n, cyc;
    launch_and_wait(34'd100, cyc);
    repeat (5) @(negedge clk);
    chk("R8 err held", 128'(err), 1);
    chk("R8 resp zero held", resp, '0);
    model(34'd2097152, r, hc, e, n);
    start = 1'b1; sectors = 34'd2097152;
    @(negedge clk); start = 1'b0;
    chk("R8 err cleared by start", 128'(err), 0);
    chk("R8 resp cleared by start", resp, '0);
    while (!done) @(negedge clk);
    chk("R8 result after clear", resp, r);
  endtask

  task automatic t_ignore;
    logic [127:0] r; bit hc, e; int n, cyc;
    model(34'd2097152, r, hc, e, n);
    launch_and_wait(34'd2097152, cyc, 3, 34'h1_0000_0400);
    chk("R10 latency unchanged", 128'(cyc), 128'(n + 2));
    chk("R10 result unchanged", resp, r);
    chk("R10 err unchanged", 128'(err), 0);
    @(negedge clk);
  endtask

  task automatic t_back_to_back;
    logic [127:0] ra, rb; bit hca, ea, hcb, eb; int na, nb, cyc;
    model(34'd20000, ra, hca, ea, na);
    model(34'd4194400, rb, hcb, eb, nb);
    launch_and_wait(34'd20000, cyc);
    chk("R11 first result at done", resp, ra);
    launch_and_wait(34'd4194400, cyc);
    chk("R11 second latency", 128'(cyc), 128'(nb + 2));
    chk("R11 second result", resp, rb);
    chk("R11 second high_cap", 128'(high_cap), 128'(hcb));
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_standard();
    t_small();
    t_hc();
    t_err_hold();
    t_ignore();
    t_back_to_back();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule